// File: doc/BRIEF.md
# Byte UART with Bus Slave Port

A byte-wide serial transmitter and receiver attached to a simple single-cycle bus slave port (strobe, write enable, 2-bit address, 8-bit data each way, acknowledge). All logic runs on the bus clock. A slower baud-reference input is synchronized into that clock domain, and each rising edge is counted. Every `BAUD_DIV` rising edges produce one oversampling tick, and four ticks make one serial bit. For example, a 500 kHz reference with a divisor of 1 gives 125 kbaud.

Software writes a byte to address 0 to queue it for sending. A one-byte holding register in front of the shifter lets a second byte be queued while the first is still on the line. Received frames are stored in a single data register. Reading address 0 returns that byte and clears the ready condition. Address 1 returns the status. Two level interrupts give the same conditions to an interrupt controller. Loopback is done externally by tying the TX pad to the RX pad.

Top module: `uart_lite`

## Requirements
- R1: After reset, `txd_o` is high, `irq_tx_o` is 1, `irq_rx_o` is 0, and a read of address 1 returns 0x02.
- R2: One serial bit lasts exactly 4*`BAUD_DIV` rising edges of `baud_ref_i`, and each transmitted start bit begins on an oversampling tick.
- R3: A transmitted frame is one low start bit, then 8 data bits least significant first, then one high stop bit. Between frames the line idles high.
- R4: Once `irq_tx_o` shows the holding register empty, a further write to address 0 is accepted. That byte follows the frame in progress with no idle time between its stop bit and the next start bit.
- R5: A write to address 0 while the holding register is full is dropped and never transmitted.
- R6: A read of address 1 returns bit 0 = received byte ready and bit 1 = holding register empty, with the other bits 0. `irq_rx_o` and `irq_tx_o` equal those two bits.
- R7: A valid frame on `rxd_i` sets the ready condition. A read of address 0 returns the byte and clears `irq_rx_o` on the next clock.
- R8: Frames arriving back to back, with only the stop bit between them, are all received correctly.
- R9: A low pulse on `rxd_i` shorter than one oversampling tick delivers no byte, and the frame that follows it is received intact.
- R10: Frames whose bit period is 3% shorter or 3% longer than nominal are received correctly.
- R11: A frame whose stop bit is sampled low is discarded and does not raise `irq_rx_o`.
- R12: `ack_o` is high in every cycle in which `stb_i` is high. Reads of addresses 2 and 3 return 0, and writes to addresses 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Bus write enable |
| adr_i | input | 2 | Register address |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data |
| ack_o | output | 1 | Bus acknowledge |
| baud_ref_i | input | 1 | Baud reference clock, asynchronous |
| rxd_i | input | 1 | Serial receive pad |
| txd_o | output | 1 | Serial transmit pad |
| irq_tx_o | output | 1 | Holding register empty |
| irq_rx_o | output | 1 | Received byte available |

## Verification
The bench sends all 256 byte values back to back into the receiver, reading each one within the following frame. It also times transmitted bits to the exact clock, so a receiver that loses a frame after the stop bit, or a transmitter that inserts an idle tick between queued bytes, shows up as wrong data or a shifted bit. It checks for a byte written while the holding register is full leaking out as a third frame, and for a short glitch or a frame with a low stop bit producing a spurious byte. Streams with bit periods 3% off nominal catch a sampling point placed too near a bit edge.

// File: rtl/uart_lite_pkg.sv
package uart_lite_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam int STAT_RX_BIT = 0;
  localparam int STAT_TX_BIT = 1;
  localparam int OVS = 4;  // ticks per bit
endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int BAUD_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic tick_o
);
  logic [2:0] ref_q;
  logic       rise;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= {ref_q[1:0], ref_i};

  assign rise = ref_q[1] & ~ref_q[2];

  generate
    if (BAUD_DIV <= 1) begin : g_nodiv
      assign tick_o = rise;
    end else begin : g_div
      localparam int CW = $clog2(BAUD_DIV);
      localparam logic [CW-1:0] LAST = CW'(BAUD_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) cnt_q <= '0;
        else if (rise) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      assign tick_o = rise && (cnt_q == LAST);
    end
  endgenerate

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);  // R2
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic       txd_o,
  output logic       empty_o
);
  import uart_lite_pkg::*;

  logic [7:0] hold_q;
  logic       hold_full_q;
  logic [9:0] sh_q;
  logic       busy_q;
  logic [1:0] sub_q;
  logic [3:0] bit_q;
  logic       bit_end, frame_end, load;

  assign bit_end   = busy_q && tick_i && (sub_q == 2'(OVS - 1));
  assign frame_end = bit_end && (bit_q == 4'd9);
  assign load      = hold_full_q && tick_i && (!busy_q || frame_end);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (wr_i && !hold_full_q) begin
      hold_q      <= wr_data_i;
      hold_full_q <= 1'b1;
    end else if (load) begin
      hold_full_q <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sh_q   <= '1;
      busy_q <= 1'b0;
      sub_q  <= '0;
      bit_q  <= '0;
    end else if (load) begin
      sh_q   <= {1'b1, hold_q, 1'b0};
      busy_q <= 1'b1;
      sub_q  <= '0;
      bit_q  <= '0;
    end else if (busy_q && tick_i) begin
      sub_q <= sub_q + 1'b1;
      if (bit_end) begin
        if (frame_end) busy_q <= 1'b0;
        else begin
          sh_q  <= {1'b1, sh_q[9:1]};
          bit_q <= bit_q + 1'b1;
        end
      end
    end

  assign txd_o   = sh_q[0];
  assign empty_o = ~hold_full_q;

  AST_TX_START_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(tick_i));  // R2
  AST_TX_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hold_full_q) |=> (hold_q == $past(hold_q)));  // R5
  AST_TX_GAPLESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && hold_full_q) |=> (busy_q && !txd_o));  // R4
  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(txd_o));  // R3
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  import uart_lite_pkg::*;

  logic [1:0] sync_q;
  logic       rx_s;
  rx_state_e  st_q;
  logic [1:0] cnt_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE:  if (!rx_s) st_q <= RX_START;
          // second tick after the edge: confirm the start bit
          RX_START: if (rx_s) st_q <= RX_IDLE;
                    else begin
                      st_q  <= RX_DATA;
                      cnt_q <= '0;
                      bit_q <= '0;
                    end
          RX_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 2'(OVS - 1)) begin
              sh_q  <= {rx_s, sh_q[7:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q == 3'd7) st_q <= RX_STOP;
            end
          end
          RX_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 2'(OVS - 1)) begin
              st_q    <= RX_IDLE;
              valid_o <= rx_s;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end

  assign byte_o = sh_q;

  AST_RX_FALSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_START && tick_i && rx_s) |=> (st_q == RX_IDLE && !valid_o));  // R9
  AST_RX_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rx_s));  // R11
endmodule

// File: rtl/uart_lite.sv
module uart_lite #(
  parameter int BAUD_DIV = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       we_i,
  input  logic [1:0] adr_i,
  input  logic [7:0] dat_i,
  output logic [7:0] dat_o,
  output logic       ack_o,
  input  logic       baud_ref_i,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       irq_tx_o,
  output logic       irq_rx_o
);
  import uart_lite_pkg::*;

  logic       tick, tx_wr, tx_empty, rx_valid, rd_data;
  logic [7:0] rx_byte, rx_data_q, status;
  logic       rx_rdy_q;

  uart_baud_tick #(.BAUD_DIV(BAUD_DIV)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(baud_ref_i), .tick_o(tick));

  assign tx_wr   = stb_i && we_i && (adr_i == ADR_DATA);
  assign rd_data = stb_i && !we_i && (adr_i == ADR_DATA);

  uart_tx_path i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .wr_i(tx_wr),
    .wr_data_i(dat_i), .txd_o(txd_o), .empty_o(tx_empty));

  uart_rx_path i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_i),
    .byte_o(rx_byte), .valid_o(rx_valid));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rx_data_q <= '0;
      rx_rdy_q  <= 1'b0;
    end else if (rx_valid) begin
      rx_data_q <= rx_byte;
      rx_rdy_q  <= 1'b1;
    end else if (rd_data) begin
      rx_rdy_q  <= 1'b0;
    end

  always_comb begin
    status = '0;
    status[STAT_RX_BIT] = rx_rdy_q;
    status[STAT_TX_BIT] = tx_empty;
    unique case (adr_i)
      ADR_DATA: dat_o = rx_data_q;
      ADR_STAT: dat_o = status;
      default:  dat_o = '0;
    endcase
  end

  assign ack_o    = stb_i;
  assign irq_tx_o = tx_empty;
  assign irq_rx_o = rx_rdy_q;

  AST_IRQ_RX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_valid) |=> !irq_rx_o);  // R7
  AST_IRQ_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid |=> irq_rx_o);  // R7
endmodule

// File: tb/test_uart_lite.sv
`timescale 1ns/1ps
module test_uart_lite;
  localparam int DIV   = 1;
  localparam int REF_H = 4;               // clk cycles per half reference period
  localparam int BIT   = 4 * DIV * 2 * REF_H;  // clk cycles per bit

  logic clk = 0, rst_n = 0, ref_clk = 0;
  logic stb = 0, we = 0, rxd = 1;
  logic [1:0] adr = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic ack, txd, irq_tx, irq_rx;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;
  initial forever #(20 * REF_H) ref_clk = ~ref_clk;

  uart_lite #(.BAUD_DIV(DIV)) i_uart_lite (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(din), .dat_o(dout), .ack_o(ack), .baud_ref_i(ref_clk),
    .rxd_i(rxd), .txd_o(txd), .irq_tx_o(irq_tx), .irq_rx_o(irq_rx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); stb = 1; we = 1; adr = a; din = d;
    @(negedge clk); stb = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic k);
    @(negedge clk); stb = 1; we = 0; adr = a;
    #2 d = dout; k = ack;
    @(negedge clk); stb = 0;
  endtask

  task automatic drive_frame(input logic [7:0] v, input int per, input bit stop_ok);
    rxd = 0; repeat (per) @(negedge clk);
    for (int b = 0; b < 8; b++) begin rxd = v[b]; repeat (per) @(negedge clk); end
    rxd = stop_ok; repeat (per) @(negedge clk);
    rxd = 1;
  endtask

  task automatic drive_stream(input int n, input int per, input int mul, input int add);
    for (int i = 0; i < n; i++) drive_frame(8'((i * mul + add) & 255), per, 1'b1);
  endtask

  task automatic wait_irq_rx(input string req);
    int t = 0;
    while (!irq_rx && t < 20 * BIT) begin @(negedge clk); t++; end
    chk(irq_rx, req, 0, 1);
  endtask

  task automatic wait_fall(output realtime tf);
    int t = 0;
    while (txd && t < 4 * BIT) begin @(negedge clk); t++; end
    chk(!txd, "R3 start", txd, 0);
    tf = $realtime;
  endtask

  // txd changed at the posedge 10 ns before tf; sample near each bit centre
  task automatic check_frame(input realtime tf, input int idx, input logic [7:0] v, input string req);
    logic [9:0] exp = {1'b1, v, 1'b0};
    for (int k = 0; k < 10; k++) begin
      #(tf + (idx * 10 + k) * BIT * 20 + (BIT / 2) * 20 - 20 - $realtime);
      chk(txd == exp[k], req, txd, exp[k]);
    end
  endtask

  // R4 / R5 scenario: check two frames continuously while the bus writes B and C
  task automatic tx_pair(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    realtime tf;
    bus_wr(0, a);
    wait_fall(tf);
    chk(irq_tx == 1, "R4 empty after load", irq_tx, 1);
    bus_wr(0, b);
    chk(irq_tx == 0, "R6 irq_tx after write", irq_tx, 0);
    bus_wr(0, c);  // dropped, holding register full
    check_frame(tf, 0, a, "R3 frame A");
    check_frame(tf, 1, b, "R4 frame B gapless");
    begin
      int lows = 0;
      repeat (12 * BIT) begin @(negedge clk); if (!txd) lows++; end
      chk(lows == 0, "R5 dropped byte not sent", lows, 0);
    end
  endtask

  initial begin
    #(20 * 190000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin : main
    logic [7:0] d; logic k;
    realtime tf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(txd == 1, "R1 txd", txd, 1);
    chk(irq_tx == 1, "R1 irq_tx", irq_tx, 1);
    chk(irq_rx == 0, "R1 irq_rx", irq_rx, 0);
    bus_rd(1, d, k);
    chk(d == 8'h02, "R1 status", d, 2);
    chk(k == 1, "R12 ack", k, 1);
    // R12 other addresses
    bus_rd(2, d, k); chk(d == 0, "R12 addr2 read", d, 0);
    bus_rd(3, d, k); chk(d == 0, "R12 addr3 read", d, 0);
    bus_wr(1, 8'hA5); bus_wr(2, 8'h3C); bus_wr(3, 8'h00);
    repeat (3 * BIT) @(negedge clk);
    chk(txd == 1, "R12 no tx from other addr", txd, 1);
    chk(irq_tx == 1, "R12 holding still empty", irq_tx, 1);

    // R2 exact start bit width with 0x01 (start low, bit0 high)
    bus_wr(0, 8'h01);
    wait_fall(tf);
    #(tf + (BIT - 2) * 20 - $realtime);
    chk(txd == 0, "R2 start still low", txd, 0);
    #(tf + (BIT) * 20 - $realtime);
    chk(txd == 1, "R2 bit0 on time", txd, 1);
    repeat (10 * BIT) @(negedge clk);

    // R3 single frames, walking and mixed patterns
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v = (i < 8) ? 8'(1 << i) : 8'((i * 73 + 29) & 255);
      bus_wr(0, v);
      wait_fall(tf);
      check_frame(tf, 0, v, "R3 frame");
      repeat (BIT) @(negedge clk);
    end

    // R4 / R5 back-to-back transmit with a dropped third write
    tx_pair(8'h81, 8'h55, 8'hF0);
    tx_pair(8'h00, 8'hFF, 8'h0F);

    // R7 / R8 exhaustive back-to-back receive
    fork drive_stream(256, BIT, 1, 0); join_none
    for (int i = 0; i < 256; i++) begin
      wait_irq_rx("R8 byte ready");
      bus_rd(1, d, k);
      chk(d == 8'h03, "R6 status rx ready", d, 3);
      bus_rd(0, d, k);
      chk(d == 8'(i), "R8 rx data", d, i);
      @(negedge clk);
      chk(irq_rx == 0, "R7 irq_rx cleared", irq_rx, 0);
    end
    repeat (2 * BIT) @(negedge clk);

    // R9 short glitch then a valid frame
    rxd = 0; repeat (4) @(negedge clk); rxd = 1;
    repeat (12 * BIT) @(negedge clk);
    chk(irq_rx == 0, "R9 glitch ignored", irq_rx, 0);
    fork drive_frame(8'hC3, BIT, 1'b1); join_none
    wait_irq_rx("R9 frame after glitch");
    bus_rd(0, d, k);
    chk(d == 8'hC3, "R9 data after glitch", d, 8'hC3);
    repeat (2 * BIT) @(negedge clk);

    // R10 bit period -3% and +3%
    for (int s = 0; s < 2; s++) begin
      int per = (s == 0) ? BIT - 1 : BIT + 1;
      fork drive_stream(16, per, 37, 5); join_none
      for (int i = 0; i < 16; i++) begin
        wait_irq_rx("R10 byte ready");
        bus_rd(0, d, k);
        chk(d == 8'((i * 37 + 5) & 255), "R10 rx data", d, (i * 37 + 5) & 255);
      end
      repeat (2 * BIT) @(negedge clk);
    end

    // R11 low stop bit; check just after the stop sample point
    drive_frame(8'h5A, BIT, 1'b0);
    repeat (BIT / 2) @(negedge clk);
    chk(irq_rx == 0, "R11 bad stop discarded", irq_rx, 0);
    repeat (14 * BIT) @(negedge clk);
    bus_rd(0, d, k);  // drain any frame seen in the tail

    done = 1;
    summary();
  end
endmodule